// File: doc/BRIEF.md
# Sequenced SD Clock Source Selector

This block picks, for each of two SD host channels, one of three source clocks: a high-frequency, a middle-frequency and a low-frequency source. Software chooses the source by writing a 2-bit code into a shared select register. Each field is guarded by write-enable bits in the upper half of the same word, so one channel can be changed without a read-modify-write of the other. The block then performs the changeover without glitches. It drains the old source on that source's own falling edge, waits until the drain is seen in the bus clock domain, and only then enables the new source after it has passed through a synchronizer in the new source's domain.

Each channel runs a small state machine with three states. S_IDLE holds the current source. The transition ACCEPT moves S_IDLE to S_DRAIN when a legal write arrives. In S_DRAIN every source request is low. The transition DRAINED moves S_DRAIN to S_FILL once all source enables read back low. In S_FILL only the target source is requested. The transition LOCKED returns S_FILL to S_IDLE once that source's enable reads back high. While a channel is outside S_IDLE, its busy bit in the status register is set.

Illegal requests are refused. These are code 0, a direct move between the two fastest sources, and any write during a changeover. A refused request leaves the selection untouched and sets a sticky per-channel error flag, which software clears by writing one to it. A change between the high and middle sources must therefore be made in two steps, through the low source.

Top module: `sd_clk_selector`

## Requirements
- R1: After reset both channels hold code 1 (high source), busy and error bits read 0, and each output runs at the high source's frequency.
- R2: The select register (address 0) holds channel c's code at bits [8c+1:8c]. Its write enables are at bits [8c+17:8c+16]. Each code bit is replaced only when its own enable bit is set, and the merged code is then judged. A write with no enable set for a channel leaves that channel unchanged.
- R3: An accepted write shows the new code on readback in the next cycle and sets the channel's busy bit (status address 1, bit c) in that same cycle.
- R4: A merged code of 0 is ignored, and it sets the channel's sticky error bit (status bit 8+c).
- R5: A request for a direct move from code 1 to code 2, or from code 2 to code 1, is ignored and sets the error bit.
- R6: A write to a channel while its busy bit is set is ignored and sets the error bit.
- R7: A write of the code already in effect while the channel is idle causes no busy and no error.
- R8: When busy clears, the channel output runs at the frequency of the selected source (code 1 high, 2 middle, 3 low).
- R9: No high or low phase of either output is shorter than half the period of the fastest source.
- R10: Busy clears within 64 bus clock cycles of an accepted write.
- R11: Writing status address 1 with bit 8+c set clears channel c's error bit. A clear with that bit at zero leaves the error bit set.
- R12: A write to one channel changes neither the code nor the output of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = select register, 1 = status register |
| bus_wdata | input | 32 | Write data with the enable mask in the upper half |
| bus_rdata | output | 32 | Read data for the register at bus_addr |
| src_clk | input | 3 | Source clocks: bit 0 high, bit 1 middle, bit 2 low |
| sd_clk_out | output | 2 | Selected clock per channel |

## Verification
The bench builds the block with its defaults: two channels, two synchronizer stages and a busy limit of 64. It drives source periods of 4, 5 and 7.5 ns. With these values, every legal transition (1→3, 3→2, 2→3, 3→1) on each channel is swept in turn. The output frequency is counted over a fixed window after each switch, and a phase-width monitor watches every output edge throughout the run. Code 0, both direct moves, partial-mask merges, writes during busy and the error clear are each exercised from known states. After every step the bench also reads the untouched channel, to check that it has not changed.

// File: rtl/sdsel_pkg.sv
package sdsel_pkg;
    localparam int CODE_W  = 2;
    localparam int NUM_SRC = 3;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_NONE = 2'd0;
    localparam code_t CODE_HI   = 2'd1;
    localparam code_t CODE_MID  = 2'd2;
    localparam code_t CODE_LO   = 2'd3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DRAIN,
        S_FILL
    } sel_state_e;

    // A move between the two fastest sources without passing the slow one.
    function automatic logic is_direct(input code_t from, input code_t to);
        return (from != CODE_LO) && (to != CODE_LO) && (to != CODE_NONE) && (to != from);
    endfunction
endpackage

// File: rtl/sdsel_lane.sv
module sdsel_lane #(
    parameter int SYNC_STAGES = 2,
    parameter bit RST_ON      = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req,
    output logic en,
    output logic gated_clk
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_q;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{RST_ON}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], req};
    end

    // Enable changes only while the source is low.
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) en_q <= RST_ON;
        else        en_q <= sync_q[SYNC_STAGES-1];
    end

    assign en        = en_q;
    assign gated_clk = src_clk & en_q;
endmodule

// File: rtl/sdsel_chan.sv
module sdsel_chan
    import sdsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_LIMIT  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    input  code_t              wr_mask,
    input  code_t              wr_bits,
    input  logic               err_clr,
    output code_t              code,
    output logic               busy,
    output logic               err,
    output logic               clk_out
);
    localparam int CNT_W = $clog2(BUSY_LIMIT + 1) + 1;

    sel_state_e         state_q, state_d;
    code_t              code_q;
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] lane_en;
    logic [NUM_SRC-1:0] lane_clk;
    logic [NUM_SRC-1:0] en_seen;
    logic               err_q;
    logic [CNT_W-1:0]   busy_cnt;

    code_t              merged;
    code_t              lane_idx;
    logic               wr_hit, accept, reject, go_fill;

    // One lane per source, each with its own synchronizer.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        logic [SYNC_STAGES-1:0] seen_q;

        sdsel_lane #(
            .SYNC_STAGES(SYNC_STAGES),
            .RST_ON     (i == 0)
        ) u_lane (
            .src_clk  (src_clk[i]),
            .rst_n    (rst_n),
            .req      (req_q[i]),
            .en       (lane_en[i]),
            .gated_clk(lane_clk[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) seen_q <= {SYNC_STAGES{i == 0}};
            else        seen_q <= {seen_q[SYNC_STAGES-2:0], lane_en[i]};
        end
        assign en_seen[i] = seen_q[SYNC_STAGES-1];
    end

    assign clk_out  = |lane_clk;
    assign merged   = (code_q & ~wr_mask) | (wr_bits & wr_mask);
    assign wr_hit   = |wr_mask;
    assign lane_idx = code_q - 2'd1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        reject  = 1'b0;
        go_fill = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
                if (wr_hit) begin
                    if (merged == CODE_NONE || is_direct(code_q, merged)) begin
                        reject = 1'b1;
                    end else if (merged != code_q) begin
                        accept  = 1'b1;
                        state_d = S_DRAIN;   // ACCEPT
                    end
                end
            end
            S_DRAIN: begin
                reject = wr_hit;
                if (en_seen == '0) begin
                    go_fill = 1'b1;
                    state_d = S_FILL;        // DRAINED
                end
            end
            S_FILL: begin
                reject = wr_hit;
                if (en_seen[lane_idx]) state_d = S_IDLE;  // LOCKED
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= CODE_HI;
            req_q  <= NUM_SRC'(1);
            err_q  <= 1'b0;
        end else begin
            if (accept)       code_q <= merged;
            if (accept)       req_q  <= '0;
            else if (go_fill) req_q  <= NUM_SRC'(1) << lane_idx;
            if (reject)       err_q  <= 1'b1;
            else if (err_clr) err_q  <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         busy_cnt <= '0;
        else if (!busy)                     busy_cnt <= '0;
        else if (busy_cnt != {CNT_W{1'b1}}) busy_cnt <= busy_cnt + 1'b1;
    end

    assign code = code_q;
    assign err  = err_q;

    // R4: the held code is never the forbidden one
    p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        code_q != CODE_NONE);

    // R5: every change of code passes through the low source
    p_no_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |-> (code_q == CODE_LO || $past(code_q) == CODE_LO));

    // R6: no change of code while a switch is in progress
    p_busy_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(code_q));

    // R9: never two source lanes enabled at once
    p_single_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_en));

    // R10: busy is bounded
    p_busy_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt < CNT_W'(BUSY_LIMIT));
endmodule

// File: rtl/sd_clk_selector.sv
module sd_clk_selector
    import sdsel_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CH_STRIDE   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_LIMIT  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic               bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_clk,
    output logic [NUM_CH-1:0]  sd_clk_out
);
    localparam int MASK_POS = 16;
    localparam int ERR_POS  = 8;

    code_t             ch_code [NUM_CH];
    logic [NUM_CH-1:0] ch_busy;
    logic [NUM_CH-1:0] ch_err;
    logic              sel_we, stat_we;
    logic              unused_wdata;

    assign sel_we       = bus_we && (bus_addr == 1'b0);
    assign stat_we      = bus_we && (bus_addr == 1'b1);
    assign unused_wdata = ^bus_wdata;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sdsel_chan #(
            .SYNC_STAGES(SYNC_STAGES),
            .BUSY_LIMIT (BUSY_LIMIT)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_clk(src_clk),
            .wr_mask(sel_we ? bus_wdata[MASK_POS + c*CH_STRIDE +: CODE_W] : code_t'(0)),
            .wr_bits(bus_wdata[c*CH_STRIDE +: CODE_W]),
            .err_clr(stat_we && bus_wdata[ERR_POS + c]),
            .code   (ch_code[c]),
            .busy   (ch_busy[c]),
            .err    (ch_err[c]),
            .clk_out(sd_clk_out[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == 1'b0) begin
                bus_rdata[c*CH_STRIDE +: CODE_W] = ch_code[c];
            end else begin
                bus_rdata[c]           = ch_busy[c];
                bus_rdata[ERR_POS + c] = ch_err[c];
            end
        end
    end

    initial begin
        a_layout_fits_r2: assert (NUM_CH * CH_STRIDE <= MASK_POS && NUM_CH <= ERR_POS);
    end
endmodule

// File: tb/sd_clk_selector_tb.sv
`timescale 1ns/1ps
module sd_clk_selector_tb;
    localparam real CLK_PERIOD = 10.0;
    localparam real HI_PER     = 4.0;
    localparam real MID_PER    = 5.0;
    localparam real LO_PER     = 7.5;
    localparam real WINDOW     = 300.0;
    localparam real MIN_PHASE  = HI_PER / 2.0 - 0.05;
    localparam int  BUSY_MAX   = 64;

    logic        clk = 0, rst_n = 0;
    logic        bus_we = 0, bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        s_hi = 0, s_mid = 0, s_lo = 0;
    logic [2:0]  src_clk;
    logic [1:0]  sd_clk_out;

    int n_tests = 0, n_fail = 0;
    int edges0 = 0, edges1 = 0, viol0 = 0, viol1 = 0;
    real last0 = 0.0, last1 = 0.0;
    bit mon_on = 0;
    int exp_code [2];

    assign src_clk = {s_lo, s_mid, s_hi};

    sd_clk_selector u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_clk(src_clk), .sd_clk_out(sd_clk_out)
    );

    initial forever #(CLK_PERIOD / 2.0) clk = ~clk;
    initial begin #0.7; forever #(HI_PER / 2.0) s_hi = ~s_hi; end
    initial begin #1.3; forever #(MID_PER / 2.0) s_mid = ~s_mid; end
    initial begin #0.4; forever #(LO_PER / 2.0) s_lo = ~s_lo; end

    always @(posedge sd_clk_out[0]) edges0++;
    always @(posedge sd_clk_out[1]) edges1++;
    always @(sd_clk_out[0]) begin
        if (mon_on && ($realtime - last0) < MIN_PHASE) viol0++;
        last0 = $realtime;
    end
    always @(sd_clk_out[1]) begin
        if (mon_on && ($realtime - last1) < MIN_PHASE) viol1++;
        last1 = $realtime;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic addr, input logic [31:0] data);
        @(negedge clk);
        bus_we = 1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_we = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic addr, output logic [31:0] data);
        bus_addr = addr;
        #1;
        data = bus_rdata;
    endtask

    function automatic logic [31:0] sel_word(input int ch, input int code, input logic [1:0] en);
        return (32'(en) << (16 + 8*ch)) | (32'(code) << (8*ch));
    endfunction

    function automatic int expect_edges(input int code);
        real per;
        per = (code == 1) ? HI_PER : (code == 2) ? MID_PER : LO_PER;
        return $rtoi(WINDOW / per);
    endfunction

    task automatic wait_idle(input int ch, input string req);
        logic [31:0] s;
        int cyc = 0;
        rd(1, s);
        while (s[ch] && cyc < 200) begin
            @(negedge clk); cyc++; rd(1, s);
        end
        check(cyc <= BUSY_MAX, req, cyc, BUSY_MAX);
    endtask

    task automatic check_freq(input int ch, input int code, input string req);
        int a, b, e;
        a = (ch == 0) ? edges0 : edges1;
        #(WINDOW);
        b = (ch == 0) ? edges0 : edges1;
        e = expect_edges(code);
        check((b - a) >= e - 1 && (b - a) <= e + 1, req, b - a, e);
        @(negedge clk);
    endtask

    task automatic check_codes(input string req);
        logic [31:0] s;
        rd(0, s);
        check(s[1:0] == 2'(exp_code[0]), req, s[1:0], exp_code[0]);
        check(s[9:8] == 2'(exp_code[1]), req, s[9:8], exp_code[1]);
    endtask

    task automatic check_err(input int ch, input bit e, input string req);
        logic [31:0] s;
        rd(1, s);
        check(s[8+ch] == e, req, s[8+ch], e);
        check(s[ch] == 1'b0, req, s[ch], 0);
    endtask

    task automatic legal_switch(input int ch, input int code);
        logic [31:0] s;
        wr(0, sel_word(ch, code, 2'b11));
        exp_code[ch] = code;
        rd(1, s);
        check(s[ch] == 1'b1, "R3 busy set", s[ch], 1);
        check_codes("R3/R12 readback");
        wait_idle(ch, "R10 busy bound");
        check_err(ch, 0, "R3 no error");
        check_freq(ch, code, "R8 output frequency");
        check_freq(1 - ch, exp_code[1-ch], "R12 other channel frequency");
    endtask

    task automatic clear_err(input int ch);
        wr(1, 32'(1) << (8 + ch));
    endtask

    initial begin
        logic [31:0] s;
        exp_code[0] = 1; exp_code[1] = 1;
        #(CLK_PERIOD * 3.3);
        rst_n = 1;
        @(negedge clk);
        mon_on = 1;

        // R1: reset state
        check_codes("R1 reset code");
        rd(1, s);
        check(s == 32'h0, "R1 reset status", s, 0);
        check_freq(0, 1, "R1 reset frequency ch0");
        check_freq(1, 1, "R1 reset frequency ch1");

        // Legal transition sweep on each channel
        for (int ch = 0; ch < 2; ch++) begin
            legal_switch(ch, 3);
            legal_switch(ch, 2);
            legal_switch(ch, 3);
            legal_switch(ch, 1);
        end

        // R4: code 0 refused
        wr(0, sel_word(0, 0, 2'b11));
        check_codes("R4 code 0 ignored");
        check_err(0, 1, "R4 error set");
        check_err(1, 0, "R12 other error untouched");
        check_freq(0, 1, "R4 output kept");
        // R11: clear with wrong bit keeps error, right bit clears
        clear_err(1);
        check_err(0, 1, "R11 unrelated clear");
        clear_err(0);
        check_err(0, 0, "R11 error cleared");

        // R5: direct 1 -> 2
        wr(0, sel_word(0, 2, 2'b11));
        check_codes("R5 direct 1-2 ignored");
        check_err(0, 1, "R5 error set 1-2");
        clear_err(0);

        // R7: same code
        wr(0, sel_word(0, 1, 2'b11));
        rd(1, s);
        check(s[0] == 1'b0, "R7 no busy", s[0], 0);
        check(s[8] == 1'b0, "R7 no error", s[8], 0);

        // R2: partial masks merge per bit
        wr(0, sel_word(0, 2, 2'b10));       // 01 -> 11
        exp_code[0] = 3;
        check_codes("R2 partial mask high bit");
        wait_idle(0, "R10 busy bound");
        wr(0, sel_word(0, 0, 2'b01));       // 11 -> 10
        exp_code[0] = 2;
        check_codes("R2 partial mask low bit");
        wait_idle(0, "R10 busy bound");
        check_freq(0, 2, "R2 merged code frequency");
        wr(0, sel_word(0, 1, 2'b00));
        check_codes("R2 no enable ignored");
        check_err(0, 0, "R2 no enable no error");

        // R5: direct 2 -> 1
        wr(0, sel_word(0, 1, 2'b11));
        check_codes("R5 direct 2-1 ignored");
        check_err(0, 1, "R5 error set 2-1");
        clear_err(0);

        // R6: write while busy
        wr(0, sel_word(0, 3, 2'b11));
        exp_code[0] = 3;
        wr(0, sel_word(0, 2, 2'b11));
        rd(1, s);
        check(s[8] == 1'b1, "R6 busy write error", s[8], 1);
        check_codes("R6 busy write ignored");
        wait_idle(0, "R10 busy bound");
        check_freq(0, 3, "R6 original target reached");
        clear_err(0);

        // R12: channel 1 moves while channel 0 stays
        legal_switch(1, 3);
        legal_switch(1, 1);

        // R9: phase widths
        check(viol0 == 0, "R9 ch0 phase width", viol0, 0);
        check(viol1 == 0, "R9 ch1 phase width", viol1, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000.0);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule